// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the oversampling enable that a UART transmitter uses to shift bits and a UART receiver uses to sample its input line. It runs entirely on the system clock and produces single-cycle enable pulses, never a derived clock. The reference clock first passes through a prescaler that passes every clock or one clock in four. The prescaled counts are then divided by a divisor made of a 16-bit integer part and a 4-bit fraction in sixteenths.

The fraction is realised by dithering. A 4-bit phase accumulator adds the fraction once per period. Each carry out of the accumulator makes the next period one prescaled count longer, so the average period equals the programmed divisor. A second counter divides the sampling ticks by 16, 8 or 4 to give a bit-rate tick.

The block has no register decoding of its own. The surrounding logic presents the divisor low byte, the divisor high byte and the fraction/oversampling field as plain inputs. A change in the divisor or the fraction restarts the divider cleanly.

Top module: `frac_brg`

## Requirements
- R1: On every clock edge at which `rst` is high, both `sample_tick` and `bit_tick` are low after that edge.
- R2: With `prescale_by4`=0 every clock is one prescaled count. With `prescale_by4`=1 one clock in four is a prescaled count, so every tick spacing is four times longer.
- R3: With a fraction of zero, `sample_tick` pulses once every D prescaled counts, where D = {`div_hi`,`div_lo`}. With the reset-default divisor of 1 it fires on every prescaled count.
- R4: With fraction F = `frac_cfg[3:0]`, any 16 consecutive sample periods contain exactly F periods of D+1 prescaled counts, and 16−F periods of D counts.
- R5: An integer divisor of 0 behaves exactly as a divisor of 1, so the generator never stalls.
- R6: `frac_cfg[5:4]` selects the oversampling ratio N: 00 gives 16, 01 gives 8, 10 and 11 give 4. `bit_tick` is a single-cycle pulse, once per N sampling ticks, and only ever in a cycle in which `sample_tick` is also high.
- R7: A change of `div_lo`, `div_hi` or `frac_cfg[3:0]` is taken at the next prescaled count. On that count no tick is produced, and the period counter, the accumulator and the bit counter are cleared. The first tick then follows D prescaled counts later, and dithering resumes from phase zero. For example, with D=6 and F=8 the periods run 6, 6, 7, 6.
- R8: With `prescale_by4`=1, `sample_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System and reference clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale_by4 | input | 1 | 0: prescale by 1, 1: prescale by 4 |
| div_lo | input | 8 | Integer divisor, low byte |
| div_hi | input | 8 | Integer divisor, high byte |
| frac_cfg | input | 6 | [3:0] fraction in sixteenths, [5:4] oversampling select |
| sample_tick | output | 1 | Single-cycle oversampling enable |
| bit_tick | output | 1 | Single-cycle bit-rate enable |

## Verification
`sample_tick` rises one clock after the prescaled count that ends a period, because the tick passes through one output register. `bit_tick` is registered in the same stage and therefore appears in the same cycle as the sample tick it accompanies. The bench drives inputs and samples outputs on the falling edge. It therefore measures spacing between ticks in falling edges rather than absolute phases. The exception is a configuration change: the first tick is due on the (D+1)th falling edge after the change is driven, one edge for the restart and D for the period, and the bench checks that exact count.

// File: rtl/frac_brg_pkg.sv
package frac_brg_pkg;

  localparam int OSR_MAX = 16;
  localparam int BCNT_W  = $clog2(OSR_MAX);

  typedef enum logic [1:0] {
    OSR_X16 = 2'b00,
    OSR_X8  = 2'b01,
    OSR_X4A = 2'b10,
    OSR_X4B = 2'b11
  } osr_sel_e;

  // last index of the bit counter for a given oversampling select
  function automatic logic [BCNT_W-1:0] osr_last(input logic [1:0] sel);
    case (osr_sel_e'(sel))
      OSR_X16: osr_last = BCNT_W'(15);
      OSR_X8:  osr_last = BCNT_W'(7);
      default: osr_last = BCNT_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/brg_prescale.sv
module brg_prescale #(
  parameter int PRE_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_div,
  output logic pre_en
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == PRE_LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + PRE_W'(1);
    end
  end

  assign pre_en = sel_div ? (cnt == PRE_LAST) : 1'b1;

endmodule

// File: rtl/brg_period.sv
module brg_period #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_en,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick_evt,
  output logic              restart_evt
);
  localparam logic [INT_W-1:0] INT_ONE = {{(INT_W-1){1'b0}}, 1'b1};
  localparam logic [INT_W:0]   CNT_ONE = {{INT_W{1'b0}}, 1'b1};

  logic [INT_W-1:0]  shd_int;
  logic [FRAC_W-1:0] shd_frac;
  logic [INT_W:0]    cnt;
  logic [FRAC_W-1:0] acc;
  logic              ext;

  logic [INT_W-1:0]  eff_div;
  logic [INT_W:0]    limit;
  logic [FRAC_W:0]   acc_sum;
  logic              cfg_changed;

  always_comb begin
    eff_div     = (shd_int == '0) ? INT_ONE : shd_int;
    limit       = {1'b0, eff_div} - CNT_ONE + {{INT_W{1'b0}}, ext};
    acc_sum     = {1'b0, acc} + {1'b0, shd_frac};
    cfg_changed = (div_int != shd_int) || (div_frac != shd_frac);
    restart_evt = pre_en && cfg_changed;
    tick_evt    = pre_en && !cfg_changed && (cnt == limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_int  <= INT_ONE;
      shd_frac <= '0;
      cnt      <= '0;
      acc      <= '0;
      ext      <= 1'b0;
    end else if (restart_evt) begin
      shd_int  <= div_int;
      shd_frac <= div_frac;
      cnt      <= '0;
      acc      <= '0;
      ext      <= 1'b0;
    end else if (tick_evt) begin
      cnt <= '0;
      acc <= acc_sum[FRAC_W-1:0];
      ext <= acc_sum[FRAC_W];
    end else if (pre_en) begin
      cnt <= cnt + CNT_ONE;
    end
  end

endmodule

// File: rtl/brg_bitdiv.sv
module brg_bitdiv
  import frac_brg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_evt,
  input  logic       restart_evt,
  input  logic [1:0] osr_sel,
  output logic       sample_tick,
  output logic       bit_tick
);
  logic [BCNT_W-1:0] bcnt;
  logic [BCNT_W-1:0] last;

  assign last = osr_last(osr_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt        <= '0;
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      sample_tick <= tick_evt;
      bit_tick    <= 1'b0;
      if (restart_evt) begin
        bcnt <= '0;
      end else if (tick_evt) begin
        if (bcnt >= last) begin
          bcnt     <= '0;
          bit_tick <= 1'b1;
        end else begin
          bcnt <= bcnt + BCNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/frac_brg.sv
module frac_brg #(
  parameter int BYTE_W  = 8,
  parameter int FRAC_W  = 4,
  parameter int PRE_DIV = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                prescale_by4,
  input  logic [BYTE_W-1:0]   div_lo,
  input  logic [BYTE_W-1:0]   div_hi,
  input  logic [FRAC_W+1:0]   frac_cfg,
  output logic                sample_tick,
  output logic                bit_tick
);
  localparam int INT_W = 2 * BYTE_W;

  logic             pre_en;
  logic             tick_evt;
  logic             restart_evt;
  logic [INT_W-1:0] div_int;

  assign div_int = {div_hi, div_lo};

  brg_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .sel_div (prescale_by4),
    .pre_en  (pre_en)
  );

  brg_period #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_per (
    .clk         (clk),
    .rst         (rst),
    .pre_en      (pre_en),
    .div_int     (div_int),
    .div_frac    (frac_cfg[FRAC_W-1:0]),
    .tick_evt    (tick_evt),
    .restart_evt (restart_evt)
  );

  brg_bitdiv u_bit (
    .clk         (clk),
    .rst         (rst),
    .tick_evt    (tick_evt),
    .restart_evt (restart_evt),
    .osr_sel     (frac_cfg[FRAC_W+1:FRAC_W]),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick)
  );

endmodule

// File: rtl/frac_brg_checker.sv
module frac_brg_checker (
  input logic clk,
  input logic rst,
  input logic prescale_by4,
  input logic sample_tick,
  input logic bit_tick
);
  localparam int GAP_W     = 20;
  localparam int STALL_MAX = 4 * 65536 + 16;

  logic             rst_q;
  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst || sample_tick) begin
      gap <= '0;
    end else if (gap != {GAP_W{1'b1}}) begin
      gap <= gap + GAP_W'(1);
    end
  end

  always @(negedge clk) begin
    if (rst_q) begin
      AST_RESET_QUIET: assert (!sample_tick && !bit_tick); // R1
    end
  end

  AST_BIT_WITH_SAMPLE: assert property (@(posedge clk) disable iff (rst) bit_tick |-> sample_tick); // R6
  AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (rst) bit_tick |=> !bit_tick); // R6
  AST_BY4_SPACING: assert property (@(posedge clk) disable iff (rst) (sample_tick && prescale_by4) |=> (!sample_tick || !prescale_by4)); // R8
  AST_NO_STALL: assert property (@(posedge clk) disable iff (rst) gap < GAP_W'(STALL_MAX)); // R5

endmodule

bind frac_brg frac_brg_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .prescale_by4 (prescale_by4),
  .sample_tick  (sample_tick),
  .bit_tick     (bit_tick)
);

// File: tb/frac_brg_bench.sv
`timescale 1ns/1ps
module frac_brg_bench;
  localparam int GAP_LIMIT = 5000;
  localparam int WATCHDOG  = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prescale_by4 = 1'b0;
  logic [7:0] div_lo = 8'h01;
  logic [7:0] div_hi = 8'h00;
  logic [5:0] frac_cfg = 6'h00;
  logic       sample_tick;
  logic       bit_tick;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  frac_brg u_frac_brg (
    .clk          (clk),
    .rst          (rst),
    .prescale_by4 (prescale_by4),
    .div_lo       (div_lo),
    .div_hi       (div_hi),
    .frac_cfg     (frac_cfg),
    .sample_tick  (sample_tick),
    .bit_tick     (bit_tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_tick(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_tick && n < GAP_LIMIT);
  endtask

  task automatic next_bit(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!bit_tick && n < GAP_LIMIT);
  endtask

  // reset with a configuration, check quiet outputs, align to a tick
  task automatic apply_cfg(input logic by4, input int dv, input logic [5:0] fc);
    int n;
    @(negedge clk);
    rst = 1'b1;
    prescale_by4 = by4;
    div_lo = dv[7:0];
    div_hi = dv[15:8];
    frac_cfg = fc;
    repeat (2) @(negedge clk);
    chk("R1 reset quiet", int'(sample_tick) + int'(bit_tick), 0);
    rst = 1'b0;
    next_tick(n);
  endtask

  task automatic t_reset;
    int g;
    apply_cfg(1'b0, 1, 6'h00);
    for (int i = 0; i < 3; i++) begin
      next_tick(g);
      chk("R3 default divisor 1", g, 1);
    end
    next_bit(g);
    next_bit(g);
    chk("R6 x16 at divisor 1", g, 16);
  endtask

  task automatic t_integer;
    int g;
    apply_cfg(1'b0, 5, 6'h00);
    for (int i = 0; i < 3; i++) begin
      next_tick(g);
      chk("R3 divisor 5", g, 5);
    end
    apply_cfg(1'b0, 300, 6'h00);
    for (int i = 0; i < 2; i++) begin
      next_tick(g);
      chk("R3 divisor 300 uses high byte", g, 300);
    end
  endtask

  task automatic t_prescale;
    int g;
    apply_cfg(1'b1, 3, 6'h00);
    for (int i = 0; i < 2; i++) begin
      next_tick(g);
      chk("R2 by4 divisor 3", g, 12);
    end
    @(negedge clk);
    chk("R8 single-cycle tick", int'(sample_tick), 0);
    apply_cfg(1'b1, 1, 6'h00);
    next_tick(g);
    chk("R2 by4 divisor 1", g, 4);
    @(negedge clk);
    chk("R8 single-cycle at divisor 1", int'(sample_tick), 0);
  endtask

  task automatic t_zero;
    int g;
    apply_cfg(1'b0, 0, 6'h00);
    next_tick(g);
    chk("R5 zero divisor by1", g, 1);
    apply_cfg(1'b1, 0, 6'h00);
    next_tick(g);
    chk("R5 zero divisor by4", g, 4);
  endtask

  task automatic frac_case(input logic by4, input int dv, input int fr);
    int g;
    int pm;
    int lng;
    int oth;
    pm = by4 ? 4 : 1;
    lng = 0;
    oth = 0;
    apply_cfg(by4, dv, 6'(fr));
    for (int i = 0; i < 16; i++) begin
      next_tick(g);
      if (g == pm * (dv + 1)) lng++;
      else if (g != pm * dv) oth++;
    end
    chk("R4 long period count", lng, fr);
    chk("R4 no stray period length", oth, 0);
  endtask

  task automatic t_fraction;
    frac_case(1'b0, 10, 4);
    frac_case(1'b0, 2, 15);
    frac_case(1'b1, 7, 1);
  endtask

  task automatic osr_case(input logic [1:0] sel, input int n);
    int g;
    apply_cfg(1'b0, 2, {sel, 4'h0});
    next_bit(g);
    next_bit(g);
    chk("R6 bit tick spacing", g, 2 * n);
    chk("R6 bit tick with sample tick", int'(sample_tick), 1);
  endtask

  task automatic t_osr;
    osr_case(2'b00, 16);
    osr_case(2'b01, 8);
    osr_case(2'b10, 4);
    osr_case(2'b11, 4);
  endtask

  task automatic t_restart;
    int g;
    apply_cfg(1'b0, 100, 6'h00);
    repeat (37) @(negedge clk);
    div_lo = 8'd3;
    div_hi = 8'd0;
    next_tick(g);
    chk("R7 first tick after change to 3", g, 4);
    next_tick(g);
    chk("R7 period after restart", g, 3);
    div_lo = 8'd6;
    frac_cfg = 6'h08;
    next_tick(g);
    chk("R7 first tick after change to 6.5", g, 7);
    next_tick(g);
    chk("R7 accumulator cleared, period 2", g, 6);
    next_tick(g);
    chk("R7 accumulator cleared, period 3", g, 7);
    next_tick(g);
    chk("R7 accumulator cleared, period 4", g, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs low in reset", int'(sample_tick) + int'(bit_tick), 0);
    t_reset();
    t_integer();
    t_prescale();
    t_zero();
    t_fraction();
    t_osr();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule